// File: doc/BRIEF.md
# Command queue dispatch engine

The engine lets a host hand work to a small fixed-function accelerator through shared local memory instead of through start and done registers. A queue region begins with a 64-byte header that holds a write index (byte offset 0) and a read index (byte offset 4). A ring of 64-byte dispatch packets follows it. The host fills the packet slot picked by its write index and then bumps the write index. The engine polls both indices. While the write index is ahead, it loads the packet, reads the argument buffer it points to, and runs the built-in kernel chosen by the kernel ID over buffer memory. It then stores a completion code where the packet asks and moves the read index forward.

All pointers carried in packets and argument buffers are byte offsets from the start of buffer memory. Each one is checked against the buffer size before any data is written. Every memory access goes through one master port. Read data arrives on the cycle after the request and holds its value until the next read. Two control inputs can halt the engine: an accelerator reset that drops any packet in flight, and an external stall that freezes the engine where it is.

Top module: `cqd_engine`

## Requirements
- R1: The engine starts a packet only when the write index (queue offset 0) is greater than the read index (queue offset 4), compared as unsigned 32-bit values. When the two are equal it writes nothing. Two packets posted together are both run, in order.
- R2: The packet slot sits at QBASE + 64 + (read index mod QDEPTH) * 64, where QDEPTH is a power of two. Its word at +0 holds the 16-bit packet header and is not interpreted. +4 holds the work-item count, +8 the kernel ID, +12 the argument-buffer offset and +16 the completion-signal offset. All queue-region reads are word aligned.
- R3: Kernel ID 0 copies count bytes from the byte offset in argument 0 to the byte offset in argument 1. Both offsets may be unaligned. Bytes outside the destination range are untouched.
- R4: Kernel ID 1 stores A[i] + B[i] modulo 2^32 into C[i] for i below count. A, B and C are 32-bit arrays at arguments 0, 1 and 3. The argument buffer is a list of 32-bit offsets: argument k sits at +4k.
- R5: Kernel ID 2 does the same as R4 but stores the low 32 bits of A[i] * B[i].
- R6: After the data work, the engine writes the 32-bit word 1 (success) or 2 (failure) at buffer offset given by the completion pointer. It skips this write when the pointer is zero.
- R7: A kernel ID above 2 completes with code 2 and writes no data.
- R8: Any pointer or array that would reach past the buffer size, or a 32-bit array pointer that is not word aligned, completes with code 2 and writes no data. The engine only ever writes inside buffer memory or to the read-index word.
- R9: After the completion write, the read index is written back as its old value plus one. Slots wrap modulo QDEPTH.
- R10: While the external stall input is high the engine makes no memory access. When it falls, the engine resumes exactly where it stopped.
- R11: While the accelerator reset input is high the engine makes no memory access and drops any packet in flight. When it falls, the engine restarts from the read index held in memory.
- R12: A work-item count of zero completes with success and writes no data.
- R13: Byte writes use a single enable bit with the byte copied to all four lanes. Word writes enable all four lanes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| accReset | input | 1 | Accelerator reset: aborts and holds the engine |
| extStall | input | 1 | External stall: freezes the engine |
| memReq | output | 1 | Memory access request this cycle |
| memWe | output | 1 | Write when high, read when low |
| memAddr | output | 32 | Byte address of the access |
| memBe | output | 4 | Byte-lane enables for writes |
| memWdata | output | 32 | Write data |
| memRdata | input | 32 | Read data, one cycle after the request, held until the next read |

## Verification
The bench builds the engine with a two-slot ring at queue base 0 and a 256-byte buffer at byte address 256. With only two slots, the third packet already lands back in slot 0, so a wrong slot computation shows up as wrong results. The small buffer lets a short array placed near its end cross the limit, which exercises the bounds failure with few elements. Unaligned byte offsets in the copy kernel exercise every lane of the byte-write path.

// File: rtl/cqd_pkg.sv
package cqd_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_RDW, S_RDR, S_CMP, S_FLD, S_ACHK, S_ARG,
    S_CHK, S_KA, S_KB, S_KW, S_SIG, S_RIX
  } state_e;

  typedef enum logic [2:0] {
    A_WIDX, A_RIDX, A_FLD, A_ARG, A_SRCA, A_SRCB, A_DST, A_SIG
  } asel_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic  req;
    logic  we;
    asel_e asel;
    logic  ldW;
    logic  ldR;
    logic  ldFld;
    logic  ldArg;
    logic  ldOpA;
    logic  clrCnt;
    logic  incCnt;
    logic  clrIter;
    logic  incIter;
    logic  setFail;
    logic  clrFail;
  } strobe_t;

  // Conditions from datapath to control
  typedef struct packed {
    logic pending;
    logic cntEnd;
    logic cntZero;
    logic kidOk;
    logic argOk;
    logic ptrOk;
    logic isCopy;
    logic lastIter;
    logic noWork;
    logic sigOn;
  } flags_t;

  localparam int unsigned SLOT_BYTES = 64;
  localparam logic [2:0]  WORDS_PER_LOAD = 3'd4;

endpackage

// File: rtl/cqd_datapath.sv
module cqd_datapath
  import cqd_pkg::*;
#(
  parameter int unsigned QBASE  = 0,
  parameter int unsigned QDEPTH = 8,
  parameter int unsigned BBASE  = 1024,
  parameter int unsigned BSIZE  = 4096
) (
  input  logic        clk,
  input  logic        rstN,
  input  strobe_t     st,
  input  logic [31:0] memRdata,
  output logic [31:0] memAddr,
  output logic [3:0]  memBe,
  output logic [31:0] memWdata,
  output flags_t      fl
);

  localparam logic [31:0] QB       = 32'(QBASE);
  localparam logic [31:0] BB       = 32'(BBASE);
  localparam logic [31:0] SLOTMASK = 32'(QDEPTH - 1);
  localparam logic [34:0] BLIM     = 35'(BSIZE);

  logic [31:0] wIdx, rIdx, workCnt, kernId, argPtr, sigPtr;
  logic [31:0] arg0, arg1, arg3, opA, iter;
  logic [2:0]  cnt;
  logic        fail;
  logic [1:0]  prevIdx;

  assign prevIdx = 2'(cnt - 3'd1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wIdx <= '0; rIdx <= '0; workCnt <= '0; kernId <= '0;
      argPtr <= '0; sigPtr <= '0; arg0 <= '0; arg1 <= '0; arg3 <= '0;
      opA <= '0; iter <= '0; cnt <= '0; fail <= 1'b0;
    end else begin
      if (st.ldW) wIdx <= memRdata;
      if (st.ldR) rIdx <= memRdata;
      if (st.ldFld) begin
        case (prevIdx)
          2'd0:    workCnt <= memRdata;
          2'd1:    kernId  <= memRdata;
          2'd2:    argPtr  <= memRdata;
          default: sigPtr  <= memRdata;
        endcase
      end
      if (st.ldArg) begin
        case (prevIdx)
          2'd0:    arg0 <= memRdata;
          2'd1:    arg1 <= memRdata;
          2'd3:    arg3 <= memRdata;
          default: ;
        endcase
      end
      if (st.ldOpA) opA <= memRdata;
      if (st.clrCnt) cnt <= '0;
      else if (st.incCnt) cnt <= cnt + 3'd1;
      if (st.clrIter) iter <= '0;
      else if (st.incIter) iter <= iter + 32'd1;
      if (st.clrFail) fail <= 1'b0;
      else if (st.setFail) fail <= 1'b1;
    end
  end

  function automatic logic fits(input logic [31:0] p, input logic [33:0] n);
    logic [34:0] e;
    e = {3'b000, p} + {1'b0, n};
    return e <= BLIM;
  endfunction

  logic        isCopy, isMul;
  logic [33:0] nBytes;
  logic [31:0] slotBase, srcOff, dstOff, iter4, cnt4;
  logic [7:0]  srcByte;
  logic [31:0] result, addr;

  assign isCopy   = (kernId == 32'd0);
  assign isMul    = (kernId == 32'd2);
  assign nBytes   = isCopy ? {2'b00, workCnt} : {workCnt, 2'b00};
  assign iter4    = {iter[29:0], 2'b00};
  assign cnt4     = 32'({cnt, 2'b00});
  assign slotBase = QB + 32'(SLOT_BYTES) + ((rIdx & SLOTMASK) << 6);
  assign srcOff   = arg0 + iter;
  assign dstOff   = arg1 + iter;

  always_comb begin
    case (srcOff[1:0])
      2'd0:    srcByte = memRdata[7:0];
      2'd1:    srcByte = memRdata[15:8];
      2'd2:    srcByte = memRdata[23:16];
      default: srcByte = memRdata[31:24];
    endcase
    if (isCopy)     result = {4{srcByte}};
    else if (isMul) result = opA * memRdata;
    else            result = opA + memRdata;
  end

  always_comb begin
    case (st.asel)
      A_WIDX:  addr = QB;
      A_RIDX:  addr = QB + 32'd4;
      A_FLD:   addr = slotBase + 32'd4 + cnt4;
      A_ARG:   addr = BB + argPtr + cnt4;
      A_SRCA:  addr = BB + (isCopy ? srcOff : arg0 + iter4);
      A_SRCB:  addr = BB + arg1 + iter4;
      A_DST:   addr = BB + (isCopy ? dstOff : arg3 + iter4);
      default: addr = BB + sigPtr;
    endcase
    memAddr  = st.req ? addr : '0;
    memBe    = 4'hF;
    memWdata = '0;
    if (st.we) begin
      case (st.asel)
        A_DST:   begin
          memWdata = result;
          if (isCopy) memBe = 4'b0001 << dstOff[1:0];
        end
        A_SIG:   memWdata = fail ? 32'd2 : 32'd1;
        default: memWdata = rIdx + 32'd1;
      endcase
    end
  end

  always_comb begin
    fl.pending  = wIdx > rIdx;
    fl.cntEnd   = (cnt == WORDS_PER_LOAD);
    fl.cntZero  = (cnt == 3'd0);
    fl.kidOk    = (kernId < 32'd3);
    fl.argOk    = (argPtr[1:0] == 2'b00) && fits(argPtr, 34'd16);
    fl.isCopy   = isCopy;
    fl.lastIter = (iter + 32'd1) == workCnt;
    fl.noWork   = (workCnt == 32'd0);
    fl.sigOn    = (sigPtr != 32'd0) && (sigPtr[1:0] == 2'b00) && fits(sigPtr, 34'd4);
    if (isCopy)
      fl.ptrOk = fits(arg0, nBytes) && fits(arg1, nBytes);
    else
      fl.ptrOk = ((arg0[1:0] | arg1[1:0] | arg3[1:0]) == 2'b00) &&
                 fits(arg0, nBytes) && fits(arg1, nBytes) && fits(arg3, nBytes);
  end

endmodule

// File: rtl/cqd_control.sv
module cqd_control
  import cqd_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    accReset,
  input  logic    extStall,
  input  flags_t  fl,
  output strobe_t st
);

  state_e state, nxt;
  strobe_t s;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nxt;
  end

  always_comb begin
    s   = '0;
    nxt = state;
    case (state)
      S_IDLE: begin s.req = 1'b1; s.asel = A_WIDX; nxt = S_RDW; end
      S_RDW:  begin s.ldW = 1'b1; s.req = 1'b1; s.asel = A_RIDX; nxt = S_RDR; end
      S_RDR:  begin s.ldR = 1'b1; nxt = S_CMP; end
      S_CMP:  begin
        s.clrFail = 1'b1; s.clrCnt = 1'b1;
        nxt = fl.pending ? S_FLD : S_IDLE;
      end
      S_FLD, S_ARG: begin
        s.asel  = (state == S_FLD) ? A_FLD : A_ARG;
        s.ldFld = (state == S_FLD) && !fl.cntZero;
        s.ldArg = (state == S_ARG) && !fl.cntZero;
        if (fl.cntEnd) begin
          s.clrCnt  = 1'b1;
          s.clrIter = 1'b1;
          nxt = (state == S_FLD) ? S_ACHK : S_CHK;
        end else begin
          s.req = 1'b1; s.incCnt = 1'b1;
        end
      end
      S_ACHK: begin
        if (!fl.kidOk || !fl.argOk) begin s.setFail = 1'b1; nxt = S_SIG; end
        else nxt = S_ARG;
      end
      S_CHK: begin
        if (!fl.ptrOk) begin s.setFail = 1'b1; nxt = S_SIG; end
        else nxt = fl.noWork ? S_SIG : S_KA;
      end
      S_KA:  begin s.req = 1'b1; s.asel = A_SRCA; nxt = fl.isCopy ? S_KW : S_KB; end
      S_KB:  begin s.ldOpA = 1'b1; s.req = 1'b1; s.asel = A_SRCB; nxt = S_KW; end
      S_KW:  begin
        s.req = 1'b1; s.we = 1'b1; s.asel = A_DST; s.incIter = 1'b1;
        nxt = fl.lastIter ? S_SIG : S_KA;
      end
      S_SIG: begin s.req = fl.sigOn; s.we = fl.sigOn; s.asel = A_SIG; nxt = S_RIX; end
      S_RIX: begin s.req = 1'b1; s.we = 1'b1; s.asel = A_RIDX; nxt = S_IDLE; end
      default: nxt = S_IDLE;
    endcase
    // Halt: accelerator reset aborts, stall freezes in place
    if (accReset) begin
      s   = '0;
      nxt = S_IDLE;
    end else if (extStall) begin
      s   = '0;
      nxt = state;
    end
  end

  assign st = s;

endmodule

// File: rtl/cqd_engine.sv
module cqd_engine
  import cqd_pkg::*;
#(
  parameter int unsigned QBASE  = 0,
  parameter int unsigned QDEPTH = 8,
  parameter int unsigned BBASE  = 1024,
  parameter int unsigned BSIZE  = 4096
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        accReset,
  input  logic        extStall,
  output logic        memReq,
  output logic        memWe,
  output logic [31:0] memAddr,
  output logic [3:0]  memBe,
  output logic [31:0] memWdata,
  input  logic [31:0] memRdata
);

  strobe_t st;
  flags_t  fl;

  cqd_control u_ctrl (
    .clk(clk), .rstN(rstN), .accReset(accReset), .extStall(extStall),
    .fl(fl), .st(st)
  );

  cqd_datapath #(
    .QBASE(QBASE), .QDEPTH(QDEPTH), .BBASE(BBASE), .BSIZE(BSIZE)
  ) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .memRdata(memRdata),
    .memAddr(memAddr), .memBe(memBe), .memWdata(memWdata), .fl(fl)
  );

  assign memReq = st.req;
  assign memWe  = st.req & st.we;

endmodule

// File: rtl/cqd_engine_chk.sv
module cqd_engine_chk #(
  parameter int unsigned QBASE  = 0,
  parameter int unsigned QDEPTH = 8,
  parameter int unsigned BBASE  = 1024,
  parameter int unsigned BSIZE  = 4096
) (
  input logic        clk,
  input logic        rstN,
  input logic        accReset,
  input logic        extStall,
  input logic        memReq,
  input logic        memWe,
  input logic [31:0] memAddr,
  input logic [3:0]  memBe
);

  localparam logic [31:0] QB   = 32'(QBASE);
  localparam logic [31:0] QEND = 32'(QBASE + 64 * (QDEPTH + 1));
  localparam logic [31:0] BB   = 32'(BBASE);
  localparam logic [31:0] BEND = 32'(BBASE + BSIZE);

  // R10
  stall_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    extStall |-> !memReq);

  // R11
  accreset_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    accReset |-> !memReq);

  // R13
  write_lanes_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memWe) |-> (memBe == 4'hF || $countones(memBe) == 1));

  // R8
  write_region_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memWe) |->
      ((memAddr >= BB && memAddr < BEND) || memAddr == QB + 32'd4));

  // R2
  queue_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memWe && memAddr >= QB && memAddr < QEND) |-> memAddr[1:0] == 2'b00);

endmodule

bind cqd_engine cqd_engine_chk #(
  .QBASE(QBASE), .QDEPTH(QDEPTH), .BBASE(BBASE), .BSIZE(BSIZE)
) i_chk (
  .clk(clk), .rstN(rstN), .accReset(accReset), .extStall(extStall),
  .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memBe(memBe)
);

// File: tb/test_cqd_engine.sv
`timescale 1ns/1ps
module test_cqd_engine;

  localparam int unsigned QB = 0;
  localparam int unsigned QD = 2;
  localparam int unsigned BB = 256;
  localparam int unsigned BS = 256;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic accReset = 1'b0;
  logic extStall = 1'b0;
  logic memReq, memWe;
  logic [31:0] memAddr, memWdata;
  logic [31:0] memRdata;
  logic [3:0]  memBe;

  logic [31:0] mem [128];
  logic        hostWe = 1'b0;
  logic [31:0] hostAddr = '0;
  logic [31:0] hostData = '0;
  int wrCount = 0;
  int holdReq = 0;
  int checks = 0;
  int errors = 0;
  int hostW = 0;

  always #4 clk = ~clk;

  cqd_engine #(.QBASE(QB), .QDEPTH(QD), .BBASE(BB), .BSIZE(BS)) i_cqd_engine (
    .clk(clk), .rstN(rstN), .accReset(accReset), .extStall(extStall),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memBe(memBe),
    .memWdata(memWdata), .memRdata(memRdata)
  );

  // Memory model: one-cycle read latency, read data held until next read
  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 128; i++) mem[i] <= '0;
      memRdata <= '0;
    end else begin
      if (memReq && memWe) begin
        for (int b = 0; b < 4; b++)
          if (memBe[b]) mem[memAddr[8:2]][8*b +: 8] <= memWdata[8*b +: 8];
        wrCount <= wrCount + 1;
      end
      if (memReq && !memWe) memRdata <= mem[memAddr[8:2]];
      if (hostWe) mem[hostAddr[8:2]] <= hostData;
      if ((extStall || accReset) && memReq) holdReq <= holdReq + 1;
    end
  end

  function automatic logic [31:0] rdW(input int unsigned a);
    return mem[a[8:2]];
  endfunction

  function automatic logic [7:0] rdB(input int unsigned a);
    logic [31:0] w;
    w = mem[a[8:2]];
    return w[8*a[1:0] +: 8];
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic hostWr(input int unsigned a, input logic [31:0] d);
    @(negedge clk);
    hostWe = 1'b1; hostAddr = 32'(a); hostData = d;
    @(negedge clk);
    hostWe = 1'b0;
  endtask

  // Post one packet; argument buffer per slot at buffer offset 160 + slot*16
  task automatic post(input logic [31:0] kid, input logic [31:0] n,
                      input logic [31:0] a0, input logic [31:0] a1,
                      input logic [31:0] a3, input logic [31:0] sigOff);
    int unsigned slot, argOff;
    slot   = QB + 64 + (hostW % QD) * 64;
    argOff = 160 + (hostW % QD) * 16;
    hostWr(slot, 32'h0000_0002);
    hostWr(slot + 4, n);
    hostWr(slot + 8, kid);
    hostWr(slot + 12, 32'(argOff));
    hostWr(slot + 16, sigOff);
    hostWr(BB + argOff, a0);
    hostWr(BB + argOff + 4, a1);
    hostWr(BB + argOff + 8, 32'h0);
    hostWr(BB + argOff + 12, a3);
    hostW++;
    hostWr(QB, 32'(hostW));
  endtask

  task automatic waitR(input int expR, input string tag);
    bit seen;
    seen = 1'b0;
    for (int i = 0; i < 3000 && !seen; i++) begin
      @(negedge clk);
      if (rdW(QB + 4) == 32'(expR)) seen = 1'b1;
    end
    chk(tag, rdW(QB + 4), 32'(expR));
  endtask

  task automatic testReset();
    repeat (40) @(negedge clk);
    chk("R1 idle read index", rdW(QB + 4), 32'd0);
    chk("R1 idle no writes", 32'(wrCount), 32'd0);
  endtask

  task automatic testCopy();
    int w0;
    for (int k = 0; k < 4; k++) hostWr(BB + 32 + 4*k, 32'h03020100 + 32'(k) * 32'h04040404);
    for (int k = 0; k < 4; k++) hostWr(BB + 128 + 4*k, 32'hAAAAAAAA);
    hostWr(BB + 16, 32'h0);
    w0 = wrCount;
    post(32'd0, 32'd7, 32'd33, 32'd130, 32'd0, 32'd16);
    waitR(1, "R9 read index after copy");
    for (int j = 0; j < 7; j++) chk("R3 copied byte", 32'(rdB(BB + 130 + j)), 32'(1 + j));
    chk("R3 byte before dst", 32'(rdB(BB + 129)), 32'hAA);
    chk("R13 byte after dst", 32'(rdB(BB + 137)), 32'hAA);
    chk("R6 success code", rdW(BB + 16), 32'd1);
    chk("R3 write count", 32'(wrCount - w0), 32'd9);
  endtask

  task automatic testArith(input logic [31:0] kid, input int expR, input string tag);
    logic [31:0] a [4];
    logic [31:0] b [4];
    logic [31:0] e;
    a = '{32'd7, 32'h0001_0001, 32'hFFFF_FFFF, 32'd100};
    b = '{32'd6, 32'h0001_0001, 32'd2, 32'h8000_0000};
    for (int k = 0; k < 4; k++) begin
      hostWr(BB + 32 + 4*k, a[k]);
      hostWr(BB + 64 + 4*k, b[k]);
      hostWr(BB + 96 + 4*k, 32'h0);
    end
    hostWr(BB + 112, 32'h5A5A5A5A);
    hostWr(BB + 16, 32'h0);
    post(kid, 32'd4, 32'd32, 32'd64, 32'd96, 32'd16);
    waitR(expR, "R9 read index after arith");
    for (int k = 0; k < 4; k++) begin
      e = (kid == 32'd2) ? a[k] * b[k] : a[k] + b[k];
      chk(tag, rdW(BB + 96 + 4*k), e);
    end
    chk("R8 sentinel past C", rdW(BB + 112), 32'h5A5A5A5A);
    chk("R6 arith success", rdW(BB + 16), 32'd1);
  endtask

  task automatic testBadKid();
    int w0;
    hostWr(BB + 96, 32'h11111111);
    hostWr(BB + 16, 32'h0);
    w0 = wrCount;
    post(32'd7, 32'd2, 32'd32, 32'd64, 32'd96, 32'd16);
    waitR(4, "R9 read index after bad kid");
    chk("R7 failure code", rdW(BB + 16), 32'd2);
    chk("R7 no data write", rdW(BB + 96), 32'h11111111);
    chk("R7 write count", 32'(wrCount - w0), 32'd2);
  endtask

  task automatic testBadPtr();
    int w0;
    hostWr(BB + 240, 32'h22222222);
    hostWr(BB + 16, 32'h0);
    w0 = wrCount;
    post(32'd1, 32'd8, 32'd32, 32'd64, 32'd240, 32'd16);
    waitR(5, "R9 read index after bad ptr");
    chk("R8 failure code", rdW(BB + 16), 32'd2);
    chk("R8 no data write", rdW(BB + 240), 32'h22222222);
    chk("R8 write count", 32'(wrCount - w0), 32'd2);
  endtask

  task automatic testZero();
    int w0;
    hostWr(BB + 0, 32'h33333333);
    hostWr(BB + 96, 32'h44444444);
    w0 = wrCount;
    post(32'd1, 32'd0, 32'd32, 32'd64, 32'd96, 32'd0);
    waitR(6, "R12 read index after empty");
    chk("R12 only index write", 32'(wrCount - w0), 32'd1);
    chk("R6 no write at zero pointer", rdW(BB + 0), 32'h33333333);
    chk("R12 C untouched", rdW(BB + 96), 32'h44444444);
  endtask

  task automatic testHold(input bit useReset, input int expR, input string tag);
    int h0;
    hostWr(BB + 32, 32'd5);
    hostWr(BB + 64, 32'd9);
    hostWr(BB + 96, 32'h0);
    hostWr(BB + 16, 32'h0);
    @(negedge clk);
    if (useReset) accReset = 1'b1; else extStall = 1'b1;
    h0 = holdReq;
    post(32'd1, 32'd1, 32'd32, 32'd64, 32'd96, 32'd16);
    repeat (60) @(negedge clk);
    chk(tag, rdW(QB + 4), 32'(expR - 1));
    chk(tag, 32'(holdReq - h0), 32'd0);
    chk(tag, rdW(BB + 96), 32'd0);
    accReset = 1'b0;
    extStall = 1'b0;
    waitR(expR, tag);
    chk(tag, rdW(BB + 96), 32'd14);
    chk(tag, rdW(BB + 16), 32'd1);
  endtask

  task automatic testBatch();
    for (int k = 0; k < 2; k++) begin
      hostWr(BB + 32 + 4*k, 32'(3 + k));
      hostWr(BB + 64 + 4*k, 32'(10 + k));
    end
    hostWr(BB + 16, 32'h0);
    hostWr(BB + 20, 32'h0);
    post(32'd1, 32'd2, 32'd32, 32'd64, 32'd96, 32'd16);
    post(32'd2, 32'd2, 32'd32, 32'd64, 32'd128, 32'd20);
    waitR(10, "R1 both packets consumed");
    chk("R1 first add", rdW(BB + 96), 32'd13);
    chk("R1 second add", rdW(BB + 100), 32'd15);
    chk("R1 first mul", rdW(BB + 128), 32'd30);
    chk("R1 second mul", rdW(BB + 132), 32'd44);
    chk("R1 first signal", rdW(BB + 16), 32'd1);
    chk("R1 second signal", rdW(BB + 20), 32'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testCopy();
    testArith(32'd1, 2, "R4 add result");
    testArith(32'd2, 3, "R5 mul result (R2 slot wrap)");
    testBadKid();
    testBadPtr();
    testZero();
    testHold(1'b0, 7, "R10 stall");
    testHold(1'b1, 8, "R11 accelerator reset");
    testBatch();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule